// File: doc/BRIEF.md
# SPI Slave-Select and Mode-Fault Controller

This block owns the select-line side of an SPI port. It works out the internal slave-select level. That level is either the synchronized select pin or a select bit written by software, depending on a management bit. When the port is an enabled master and is set up to drive the select line, the block drives that line low. It also holds the port-enable and master bits of the control register.

A port that is set up as a master without driving its own select line is watching for a second master. If the internal select level goes low in that state, another master has taken the bus. The block then raises a mode-fault flag and, at the same clock edge, drops both the enable bit and the master bit, so the port falls back to an idle slave. While the flag is set, software cannot turn either bit back on. Software clears the flag by accessing the status register and then writing the control register. An interrupt line reports the fault when software has enabled it.

The shift engine and the CRC logic sit outside this block. The shift engine uses the slave-active output to know when a slave-mode frame may run.

Top module: `spi_sel_fault_ctrl`

## Requirements
- R1: After a synchronous active-low reset, enable, master, fault flag, interrupt, select-drive enable and slave-active are all 0, and the select level reads 1 (inactive).
- R2: When software management is on (write-data bit 2 = 1), the select level equals the software select bit (bit 3), and the select pin has no effect on it.
- R3: When software management is off, the select level follows the select pin after exactly two rising clock edges.
- R4: The select-drive enable is 1 only when all four of these hold: software management is off, the drive bit (bit 4) is 1, master (bit 1) is 1 and enable (bit 0) is 1. The driven level is always 0.
- R5: Slave-active is 1 exactly when the port is enabled, the master bit is 0 and the select level is 0.
- R6: A master that is not configured to drive its own select line (drive bit 0, or software management on) raises the fault flag and clears enable and master at the edge after its select level is seen low. The low level may come from the pin or from the software select bit.
- R7: The fault flag clears only on a control write that directly follows a status access made while the flag was set. A control write with no such preceding access leaves the flag set.
- R8: While the fault flag is set, a control write cannot set enable or master, including the write that clears the flag. The other control fields of that write do take effect.
- R9: The interrupt output is 1 when the fault flag is set and the interrupt-enable bit (bit 5) is 1.
- R10: When a control write that sets enable and master lands in the same cycle as a detected fault, the fault wins: both bits end up 0 and the flag is set.
- R11: A status access in the same cycle as a control write does not arm the clear, so the next control write leaves the fault flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nss_pin_i | input | 1 | Select pin level, asynchronous |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 6 | Control write data: bit 0 enable, 1 master, 2 software management, 3 software select, 4 select drive, 5 interrupt enable |
| stat_acc_i | input | 1 | Status register read or write strobe |
| port_en_o | output | 1 | Port enable bit |
| master_o | output | 1 | Master bit |
| modf_o | output | 1 | Mode-fault flag |
| err_irq_o | output | 1 | Error interrupt |
| sel_n_o | output | 1 | Internal select level, active low |
| nss_out_o | output | 1 | Level driven on the select line |
| nss_oe_o | output | 1 | Select-line drive enable |
| slave_active_o | output | 1 | Slave frame may run |

## Verification
Fault detection and a control write can both land in the same cycle. The bench provokes this by lowering the select pin while the port is an enabled master without select drive. It waits the two synchronizer edges, then issues a write that sets enable and master on the very edge where the fault registers. The result is correct only if the flag is set and both bits read 0. The same collision arises many times during the random phase, where a bench model computed from the requirements judges every output on every cycle.

// File: rtl/sel_fault_pkg.sv
// Shared types for the SPI select and mode-fault controller.
// Assumes the control write word is packed with enable in bit 0.
package sel_fault_pkg;
    typedef struct packed {
        logic err_ie;
        logic nss_drv;
        logic sw_sel;
        logic sw_mgmt;
        logic master;
        logic en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/nss_sync.sv
// Multi-flop synchronizer for the asynchronous select pin.
// Assumes at least two stages; resets to the inactive (high) level.
module nss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b1;
                    else        stage_q[0] <= d_i;
                end
            end else begin : g_next
                // later stages pass the level along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 1'b1;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sel_level.sv
// Resolves the internal select level and the select-line drive. It also
// flags a foreign bus claim when this port is a listening master.
// Assumes all inputs are register outputs or synchronized levels.
module sel_level (
    input  logic nss_sync_i,
    input  logic en_i,
    input  logic master_i,
    input  logic sw_mgmt_i,
    input  logic sw_sel_i,
    input  logic nss_drv_i,
    output logic sel_n_o,
    output logic nss_oe_o,
    output logic slave_active_o,
    output logic claim_o
);
    logic self_drive_cfg;

    // pick the select source and derive drive, slave and claim terms
    always_comb begin
        sel_n_o        = sw_mgmt_i ? sw_sel_i : nss_sync_i;
        self_drive_cfg = nss_drv_i && !sw_mgmt_i;
        nss_oe_o       = self_drive_cfg && master_i && en_i;
        slave_active_o = en_i && !master_i && !sel_n_o;
        claim_o        = master_i && !self_drive_cfg && !sel_n_o;
    end
endmodule

// File: rtl/fault_core.sv
// Holds the control fields, the mode-fault flag and the clear-sequence
// armed bit. A claim clears enable and master; they stay locked until a
// status access followed by a control write clears the flag.
module fault_core
    import sel_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr_i,
    input  ctl_t ctl_wdata_i,
    input  logic stat_acc_i,
    input  logic claim_i,
    output ctl_t ctl_o,
    output logic modf_o
);
    ctl_t ctl_q, ctl_d;
    logic modf_q, modf_d;
    logic armed_q, armed_d;

    // next state of control fields, flag and armed bit
    always_comb begin
        ctl_d   = ctl_q;
        modf_d  = modf_q;
        armed_d = armed_q;
        if (ctl_wr_i) begin
            ctl_d        = ctl_wdata_i;
            ctl_d.en     = ctl_wdata_i.en && !modf_q;
            ctl_d.master = ctl_wdata_i.master && !modf_q;
            armed_d      = 1'b0;
            if (armed_q) modf_d = 1'b0;
        end else if (stat_acc_i && modf_q) begin
            armed_d = 1'b1;
        end
        if (claim_i) begin
            ctl_d.en     = 1'b0;
            ctl_d.master = 1'b0;
            modf_d       = 1'b1;
        end
    end

    // state registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            modf_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            modf_q  <= modf_d;
            armed_q <= armed_d;
        end
    end

    assign ctl_o  = ctl_q;
    assign modf_o = modf_q;

    // a claim drops the port out of master mode at the next edge
    assert_claim_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |=> (modf_q && !ctl_q.en && !ctl_q.master));

    // writes while faulted never raise enable or master
    assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (modf_q && ctl_wr_i) |=> (!ctl_q.en && !ctl_q.master));

    // the flag only falls after an armed control write
    assert_clear_sequence_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modf_q) |-> $past(ctl_wr_i && armed_q));
endmodule

// File: rtl/spi_sel_fault_ctrl.sv
// Top of the SPI select and mode-fault controller: a pin synchronizer,
// select resolution and the fault/control register core.
// Assumes strobes are single-cycle and synchronous to clk.
module spi_sel_fault_ctrl
    import sel_fault_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nss_pin_i,
    input  logic             ctl_wr_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    input  logic             stat_acc_i,
    output logic             port_en_o,
    output logic             master_o,
    output logic             modf_o,
    output logic             err_irq_o,
    output logic             sel_n_o,
    output logic             nss_out_o,
    output logic             nss_oe_o,
    output logic             slave_active_o
);
    logic nss_s;
    logic claim;
    ctl_t ctl;

    nss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (nss_pin_i),
        .q_o   (nss_s)
    );

    sel_level u_sel (
        .nss_sync_i     (nss_s),
        .en_i           (ctl.en),
        .master_i       (ctl.master),
        .sw_mgmt_i      (ctl.sw_mgmt),
        .sw_sel_i       (ctl.sw_sel),
        .nss_drv_i      (ctl.nss_drv),
        .sel_n_o        (sel_n_o),
        .nss_oe_o       (nss_oe_o),
        .slave_active_o (slave_active_o),
        .claim_o        (claim)
    );

    fault_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_i    (ctl_wr_i),
        .ctl_wdata_i (ctl_t'(ctl_wdata_i)),
        .stat_acc_i  (stat_acc_i),
        .claim_i     (claim),
        .ctl_o       (ctl),
        .modf_o      (modf_o)
    );

    // output mapping and fault interrupt
    always_comb begin
        port_en_o = ctl.en;
        master_o  = ctl.master;
        err_irq_o = modf_o && ctl.err_ie;
        nss_out_o = 1'b0;
    end

    // drive only ever happens from an enabled master
    assert_drive_only_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nss_oe_o |-> (master_o && port_en_o));

    // a slave frame never runs while this port is master
    assert_slave_not_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slave_active_o |-> (!master_o && port_en_o));
endmodule

// File: tb/spi_sel_fault_ctrl_tb.sv
module spi_sel_fault_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nss_pin = 1'b1;
    logic ctl_wr = 1'b0;
    logic [5:0] wdata = '0;
    logic stat_acc = 1'b0;
    logic port_en, master, modf, err_irq, sel_n, nss_out, nss_oe, slave_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // bench model state
    bit m_s1, m_s2, m_en, m_ms, m_sm, m_ss, m_dr, m_ie, m_modf, m_arm;

    always #2.5 clk = ~clk;

    spi_sel_fault_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nss_pin_i(nss_pin), .ctl_wr_i(ctl_wr),
        .ctl_wdata_i(wdata), .stat_acc_i(stat_acc), .port_en_o(port_en),
        .master_o(master), .modf_o(modf), .err_irq_o(err_irq), .sel_n_o(sel_n),
        .nss_out_o(nss_out), .nss_oe_o(nss_oe), .slave_active_o(slave_active)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_sel();
        return m_sm ? m_ss : m_s2;
    endfunction

    // one clock: advance model from requirements, then compare at negedge
    task automatic step();
        bit sel, fc, n_en, n_ms, n_modf, n_arm;
        @(posedge clk);
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_en = 0; m_ms = 0; m_sm = 0; m_ss = 0;
            m_dr = 0; m_ie = 0; m_modf = 0; m_arm = 0;
        end else begin
            sel = exp_sel();
            fc = m_ms && !(m_dr && !m_sm) && !sel;
            n_en = m_en; n_ms = m_ms; n_modf = m_modf; n_arm = m_arm;
            if (ctl_wr) begin
                n_en = wdata[0] && !m_modf;
                n_ms = wdata[1] && !m_modf;
                m_sm = wdata[2]; m_ss = wdata[3]; m_dr = wdata[4]; m_ie = wdata[5];
                n_arm = 0;
                if (m_arm) n_modf = 0;
            end else if (stat_acc && m_modf) begin
                n_arm = 1;
            end
            if (fc) begin n_en = 0; n_ms = 0; n_modf = 1; end
            m_s2 = m_s1; m_s1 = nss_pin;
            m_en = n_en; m_ms = n_ms; m_modf = n_modf; m_arm = n_arm;
        end
        @(negedge clk);
        if (rst_n) begin
            chk("R6", "port_en", port_en, m_en);
            chk("R6", "master", master, m_ms);
            chk("R3", "sel_n", sel_n, exp_sel());
            chk("R4", "nss_oe", nss_oe, !m_sm && m_dr && m_ms && m_en);
            chk("R4", "nss_out", nss_out, 1'b0);
            chk("R5", "slave_active", slave_active, m_en && !m_ms && !exp_sel());
            chk("R7", "modf", modf, m_modf);
            chk("R9", "err_irq", err_irq, m_modf && m_ie);
        end
    endtask

    task automatic wr(input logic [5:0] d);
        ctl_wr = 1; wdata = d; step(); ctl_wr = 0;
    endtask

    task automatic sa();
        stat_acc = 1; step(); stat_acc = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        process::self().srandom(32'h5E1F);
        step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1", "port_en", port_en, 0); chk("R1", "master", master, 0);
        chk("R1", "modf", modf, 0); chk("R1", "err_irq", err_irq, 0);
        chk("R1", "nss_oe", nss_oe, 0); chk("R1", "sel_n", sel_n, 1);
        chk("R1", "slave_active", slave_active, 0);

        // R2 software select ignores pin
        wr(6'b001100);
        nss_pin = 0; step(); step(); step();
        chk("R2", "sel_n sw high", sel_n, 1);
        wr(6'b000100);
        chk("R2", "sel_n sw low", sel_n, 0);

        // R3 two-edge synchronizer delay
        wr(6'b000000);
        chk("R3", "sel_n pin low", sel_n, 0);
        nss_pin = 1; step();
        chk("R3", "sel_n after one edge", sel_n, 0);
        step();
        chk("R3", "sel_n after two edges", sel_n, 1);

        // R4 drive enable, no fault while driving
        wr(6'b010011);
        chk("R4", "nss_oe", nss_oe, 1); chk("R4", "nss_out", nss_out, 0);
        nss_pin = 0; step(); step(); step();
        chk("R6", "no fault while driving", modf, 0);
        chk("R6", "enable kept", port_en, 1);

        // R5 slave active
        wr(6'b000001);
        chk("R5", "slave_active", slave_active, 1);
        nss_pin = 1; step(); step();
        chk("R5", "slave idle", slave_active, 0);

        // R6 fault from pin
        wr(6'b000011);
        nss_pin = 0; step(); step();
        chk("R6", "no fault yet", modf, 0);
        step();
        chk("R6", "modf", modf, 1); chk("R6", "en", port_en, 0); chk("R6", "ms", master, 0);
        chk("R9", "irq off", err_irq, 0);

        // R8 blocked write, other fields apply; R7 no clear without status
        wr(6'b100011);
        chk("R8", "en blocked", port_en, 0); chk("R8", "ms blocked", master, 0);
        chk("R9", "irq on", err_irq, 1); chk("R7", "modf kept", modf, 1);

        // R7 proper clear; clearing write still blocked (R8)
        nss_pin = 1; step(); step();
        sa(); wr(6'b100011);
        chk("R7", "modf cleared", modf, 0); chk("R8", "clear write blocked", port_en, 0);
        chk("R9", "irq off after clear", err_irq, 0);
        wr(6'b100011);
        chk("R8", "en unlocked", port_en, 1); chk("R8", "ms unlocked", master, 1);

        // R10 fault and write in the same cycle
        nss_pin = 0; step(); step();
        wr(6'b100011);
        chk("R10", "modf", modf, 1); chk("R10", "en", port_en, 0); chk("R10", "ms", master, 0);

        // R11 simultaneous status access and write does not arm
        stat_acc = 1; ctl_wr = 1; wdata = 6'b000000; step(); stat_acc = 0; ctl_wr = 0;
        wr(6'b000000);
        chk("R11", "modf kept", modf, 1);
        sa(); wr(6'b000000);
        chk("R7", "modf cleared again", modf, 0);

        // R6 fault from software select bit
        nss_pin = 1;
        wr(6'b000111);
        step();
        chk("R6", "sw fault modf", modf, 1); chk("R6", "sw fault en", port_en, 0);
        sa(); wr(6'b000000);

        // random phase against the model
        for (int i = 0; i < 3000; i++) begin
            ctl_wr = ($urandom_range(0, 4) == 0);
            stat_acc = ($urandom_range(0, 4) == 0);
            wdata = 6'($urandom);
            if ($urandom_range(0, 9) == 0) nss_pin = ~nss_pin;
            step();
        end
        ctl_wr = 0; stat_acc = 0;
        finish_run();
    end
endmodule